// File: doc/BRIEF.md
# Gated Retriggerable One-Shot Timer

This block is a clocked pulse stretcher. It watches two groups of gate inputs and a clear line. When a qualifying edge arrives it drives a pulse of a programmed number of clock cycles. The gates in each group are combined by AND:

- The first group is active low. Its AND is called the effective A term.
- The second group is active high. Its AND is called the effective B term.

A qualifying edge that arrives while a pulse is already running starts the count again from its full length. This lets the output stay high with no gap for as long as triggers keep arriving. A trigger that comes too soon after the last accepted one is dropped. "Too soon" means inside a programmable recovery window.

Every gate input and the clear line pass through a two-flop synchroniser before edge detection, so all of them may be asynchronous. The width and recovery values are sampled on the clock edge that accepts a trigger. They are assumed to be static or driven from the timer's own clock.

The block resets synchronously to an idle state. During reset the clear line is treated as asserted.

Top module: `oneshot_timer`

## Requirements
- R1: While the synchronised clear input (`clr_n`, active low) is low, `pulse_o` is 0 and `pulse_n_o` is 1. A pulse in progress ends on the third clock edge after `clr_n` falls.
- R2: No pulse starts while effective A is 1 or effective B is 0.
- R3: A rising edge on effective B starts a pulse when clear is high and effective A is 0.
- R4: A falling edge on effective A starts a pulse when clear is high and effective B is 1.
- R5: A rising edge on clear starts a pulse when effective A is 0 and effective B is 1. This trigger is taken in the first cycle that the synchronised clear is seen high.
- R6: Effective A is the AND of `gate_lo_n[1:0]`. Lowering either bit while the other is 1 is a falling edge. Effective B is the AND of `gate_hi[1:0]`.
- R7: `pulse_o` rises on the third rising clock edge after the triggering input change. It stays high for exactly `width_i` cycles.
- R8: An accepted trigger during a pulse restarts the full `width_i` count from that trigger, so back-to-back triggers hold `pulse_o` high without a gap.
- R9: After an accepted trigger on edge e, a trigger that would be accepted on edges e+1 through e+`recov_i` is ignored.
- R10: An accepted trigger with `width_i` = 0 produces no pulse and ends any running pulse.
- R11: `pulse_n_o` is always the inverse of `pulse_o`.
- R12: After reset, with the gates idle (`gate_lo_n`=11, `gate_hi`=00, `clr_n`=1), `pulse_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gate_lo_n | input | 2 | Active-low gate pair (ANDed into effective A) |
| gate_hi | input | 2 | Active-high gate pair (ANDed into effective B) |
| clr_n | input | 1 | Active-low clear; its rising edge can also trigger |
| width_i | input | W_BITS | Pulse length in clock cycles |
| recov_i | input | R_BITS | Recovery window length in clock cycles |
| pulse_o | output | 1 | Timer output |
| pulse_n_o | output | 1 | Complement of `pulse_o` |

## Verification
Every input change takes three rising edges to show at the outputs: two for the synchroniser and one for the counter load or clear. A pulse then ends `width_i` edges after it rose. The bench drives inputs on the falling edge. It advances a reference model on each rising edge using the same three-stage delay, and compares both outputs against that model on every falling edge. Directed cases set up each trigger kind, clear, the recovery window and a zero width at known distances from one another. Random gate activity then covers retriggers that fall just inside and just outside the window.

// File: rtl/otm_pkg.sv
// Shared types for the one-shot timer.
// Assumes: nothing beyond the standard language.
package otm_pkg;

    // Synchronised, combined view of the trigger inputs.
    typedef struct packed {
        logic a_eff;   // AND of the active-low gate pair
        logic b_eff;   // AND of the active-high gate pair
        logic clr;     // clear line, 1 = released
    } gate_t;

    localparam int SYNC_STAGES = 2;

endpackage

// File: rtl/otm_sync.sv
// Multi-bit flop-chain synchroniser with a per-bit reset value.
// Assumes: each bit is independent; no bus coherence is needed.
module otm_sync #(
    parameter int          N       = 1,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    logic [N-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift one stage of the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n)      chain[s] <= RST_VAL;
                else if (s == 0) chain[s] <= d;
                else             chain[s] <= chain[(s > 0) ? s-1 : 0];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/otm_trigger.sv
// Edge qualifier: keeps the previous gate state and flags the three trigger kinds.
// Assumes: inputs are synchronised; the reset state matches an idle, cleared line.
module otm_trigger
    import otm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  gate_t cur_i,
    output logic  trig_o
);

    gate_t prev_q;
    logic  b_rise, a_fall, c_rise;

    // Remember last cycle's gate state for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '{a_eff: 1'b1, b_eff: 1'b0, clr: 1'b0};
        else        prev_q <= cur_i;
    end

    // Qualify each edge by the levels of the other two terms.
    always_comb begin
        b_rise = cur_i.b_eff & ~prev_q.b_eff & ~cur_i.a_eff & cur_i.clr;
        a_fall = ~cur_i.a_eff & prev_q.a_eff & cur_i.b_eff & cur_i.clr;
        c_rise = cur_i.clr & ~prev_q.clr & ~cur_i.a_eff & cur_i.b_eff;
        trig_o = b_rise | a_fall | c_rise;
    end

    // R2: a trigger never appears while the gates are disarmed
    a_r2_disarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_i.a_eff || !cur_i.b_eff) |-> !trig_o);

endmodule

// File: rtl/otm_timer.sv
// Pulse and recovery down-counters.
// A trigger is accepted only when recovery has expired; clear has priority.
// Assumes: clr_i and trig_i are synchronous; width_i and recov_i are stable at acceptance.
module otm_timer #(
    parameter int W_BITS = 8,
    parameter int R_BITS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              trig_i,
    input  logic [W_BITS-1:0] width_i,
    input  logic [R_BITS-1:0] recov_i,
    output logic              busy_o
);

    logic [W_BITS-1:0] pulse_cnt;
    logic [R_BITS-1:0] rec_cnt;
    logic              accept;

    assign accept = clr_i & trig_i & (rec_cnt == '0);

    // Load, hold-down or clear the pulse counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_i)    pulse_cnt <= '0;
        else if (accept)         pulse_cnt <= width_i;
        else if (pulse_cnt != 0) pulse_cnt <= pulse_cnt - 1'b1;
    end

    // Track the recovery window after each accepted trigger.
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_i)  rec_cnt <= '0;
        else if (accept)       rec_cnt <= recov_i;
        else if (rec_cnt != 0) rec_cnt <= rec_cnt - 1'b1;
    end

    assign busy_o = (pulse_cnt != '0);

    // R1: clear empties the pulse on the next edge
    a_r1_clear_ends: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> !busy_o);

    // R8: an accepted trigger reloads the full width
    a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> pulse_cnt == $past(width_i));

    // R9: a trigger inside the recovery window leaves the count running down
    a_r9_window_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && clr_i && rec_cnt != '0) |=>
        (pulse_cnt == $past(pulse_cnt) - W_BITS'($past(pulse_cnt) != '0)));

    // R7: the pulse only starts from a trigger seen one edge earlier
    a_r7_start_from_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(pulse_cnt) == '0) |-> $past(trig_i));

endmodule

// File: rtl/oneshot_timer.sv
// Top of the gated retriggerable one-shot.
// Synchronises the gates and clear, detects qualified edges, and runs the timers.
// Assumes: gate and clear inputs may be asynchronous; width_i and recov_i are not.
module oneshot_timer #(
    parameter int W_BITS = 8,
    parameter int R_BITS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        gate_lo_n,
    input  logic [1:0]        gate_hi,
    input  logic              clr_n,
    input  logic [W_BITS-1:0] width_i,
    input  logic [R_BITS-1:0] recov_i,
    output logic              pulse_o,
    output logic              pulse_n_o
);
    import otm_pkg::*;

    localparam int            NSYNC    = 5;
    localparam logic [NSYNC-1:0] IDLE_VAL = 5'b11_00_0;

    logic [NSYNC-1:0] raw, syn;
    gate_t            gates;
    logic             trig, busy;

    assign raw = {gate_lo_n, gate_hi, clr_n};

    otm_sync #(.N(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_VAL)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
    );

    // Combine each gate pair into its effective term.
    always_comb begin
        gates.a_eff = &syn[4:3];
        gates.b_eff = &syn[2:1];
        gates.clr   = syn[0];
    end

    otm_trigger u_trig (
        .clk(clk), .rst_n(rst_n), .cur_i(gates), .trig_o(trig)
    );

    otm_timer #(.W_BITS(W_BITS), .R_BITS(R_BITS)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr_i(gates.clr), .trig_i(trig),
        .width_i(width_i), .recov_i(recov_i), .busy_o(busy)
    );

    assign pulse_o   = busy;
    assign pulse_n_o = ~busy;

endmodule

// File: tb/oneshot_timer_tb.sv
// Bench: reference model advanced on rising edges; outputs compared on falling edges.
module oneshot_timer_tb;

    localparam int W_BITS = 8;
    localparam int R_BITS = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        gate_lo_n = 2'b11;
    logic [1:0]        gate_hi = 2'b00;
    logic              clr_n = 1'b1;
    logic [W_BITS-1:0] width_i = 8'd5;
    logic [R_BITS-1:0] recov_i = 6'd0;
    logic              pulse_o, pulse_n_o;

    int    n_chk = 0, n_bad = 0, cyc = 0;
    string cur_req = "R12";
    bit    chk_en = 1'b0;

    // Reference model state
    logic [4:0]        m1, m2;
    logic              pa, pb, pc;
    logic [W_BITS-1:0] mcnt;
    logic [R_BITS-1:0] mrec;

    always #2 clk = ~clk;   // 250 MHz

    oneshot_timer #(.W_BITS(W_BITS), .R_BITS(R_BITS)) u_dut (
        .clk(clk), .rst_n(rst_n), .gate_lo_n(gate_lo_n), .gate_hi(gate_hi),
        .clr_n(clr_n), .width_i(width_i), .recov_i(recov_i),
        .pulse_o(pulse_o), .pulse_n_o(pulse_n_o)
    );

    function automatic logic fire_f(logic a, logic b, logic c, logic qa, logic qb, logic qc);
        return c && ((b && !qb && !a) || (!a && qa && b) || (!qc && !a && b));
    endfunction

    function automatic logic [W_BITS-1:0] dec_w(logic [W_BITS-1:0] v);
        return (v == 0) ? v : v - 1'b1;
    endfunction

    // Advance the model one clock.
    always @(posedge clk) begin
        logic a, b, c, f;
        if (!rst_n) begin
            m1 = 5'b11_00_0; m2 = 5'b11_00_0;
            pa = 1'b1; pb = 1'b0; pc = 1'b0; mcnt = '0; mrec = '0;
        end else begin
            a = &m2[4:3]; b = &m2[2:1]; c = m2[0];
            f = fire_f(a, b, c, pa, pb, pc);
            if (!c) begin
                mcnt = '0; mrec = '0;
            end else if (f && mrec == 0) begin
                mcnt = width_i; mrec = recov_i;
            end else begin
                mcnt = dec_w(mcnt);
                if (mrec != 0) mrec = mrec - 1'b1;
            end
            pa = a; pb = b; pc = c;
            m2 = m1; m1 = {gate_lo_n, gate_hi, clr_n};
        end
    end

    task automatic summary_and_end();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Compare outputs to the model away from the active edge; watchdog.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual cycles=%0d expected <=100000", cyc);
            summary_and_end();
        end
        if (chk_en) begin
            n_chk++;
            if (pulse_o !== (mcnt != 0)) begin
                n_bad++;
                $display("FAIL %s: pulse_o actual=%b expected=%b at cycle %0d",
                         cur_req, pulse_o, (mcnt != 0), cyc);
            end
            n_chk++;
            if (pulse_n_o !== ~pulse_o) begin   // R11
                n_bad++;
                $display("FAIL R11: pulse_n_o actual=%b expected=%b", pulse_n_o, ~pulse_o);
            end
        end
    end

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd2024));
        wait_cyc(3);
        rst_n = 1'b1;
        chk_en = 1'b1;
        cur_req = "R12"; wait_cyc(10);

        // R3: B rising with A low
        cur_req = "R3"; gate_lo_n = 2'b00; wait_cyc(4);
        gate_hi = 2'b11; wait_cyc(12);

        // R6 and R4: one low-active input drops while the other is high
        cur_req = "R6"; gate_lo_n = 2'b11; wait_cyc(5);
        cur_req = "R4"; gate_lo_n = 2'b10; wait_cyc(12);

        // R1: clear cuts a running pulse short
        cur_req = "R1"; width_i = 8'd20; gate_lo_n = 2'b11; wait_cyc(4);
        gate_lo_n = 2'b01; wait_cyc(6);
        clr_n = 1'b0; wait_cyc(6);

        // R5: rising clear with A low, B high
        cur_req = "R5"; width_i = 8'd4; clr_n = 1'b1; wait_cyc(10);

        // R2: gates disarmed, B toggling does nothing
        cur_req = "R2"; gate_lo_n = 2'b11;
        for (int i = 0; i < 4; i++) begin
            gate_hi = 2'b00; wait_cyc(3); gate_hi = 2'b11; wait_cyc(3);
        end

        // R8: retriggers every 4 cycles keep the pulse high (recovery 2)
        cur_req = "R8"; gate_lo_n = 2'b00; width_i = 8'd6; recov_i = 6'd2;
        for (int i = 0; i < 5; i++) begin
            gate_hi = 2'b00; wait_cyc(2); gate_hi = 2'b11; wait_cyc(2);
        end
        wait_cyc(10);

        // R9: a retrigger 4 cycles later is inside a 10-cycle window
        cur_req = "R9"; recov_i = 6'd10; width_i = 8'd8;
        gate_hi = 2'b00; wait_cyc(2); gate_hi = 2'b11; wait_cyc(2);
        gate_hi = 2'b00; wait_cyc(2); gate_hi = 2'b11; wait_cyc(20);

        // R10: a zero width ends a running pulse and starts none
        cur_req = "R10"; recov_i = 6'd0; width_i = 8'd12;
        gate_hi = 2'b00; wait_cyc(2); gate_hi = 2'b11; wait_cyc(5);
        width_i = 8'd0;
        gate_hi = 2'b00; wait_cyc(2); gate_hi = 2'b11; wait_cyc(10);

        // R7: random gates, widths and windows checked against the model
        cur_req = "R7";
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 3) == 0) gate_lo_n = 2'($urandom);
            if ($urandom_range(0, 3) == 0) gate_hi   = 2'($urandom);
            if ($urandom_range(0, 40) == 0) clr_n    = ~clr_n;
            else if (!clr_n && $urandom_range(0, 3) == 0) clr_n = 1'b1;
            if ($urandom_range(0, 20) == 0) width_i  = 8'($urandom_range(0, 15));
            if ($urandom_range(0, 20) == 0) recov_i  = 6'($urandom_range(0, 7));
            wait_cyc(1);
        end
        summary_and_end();
    end

endmodule